// File: doc/BRIEF.md
# Snoop Hold and Backoff Arbiter

This block sits on the system side of a shared bus. It coordinates an external bus master with a processor that snoops its own cache. The processor normally sits in hold while the master owns the bus. Each address strobe from the master is passed straight to the processor as a snoop strobe in the same clock. A fixed number of clocks later, the arbiter looks at the processor's hit-to-modified response. If the snooped line is dirty, the arbiter lets go of the processor's hold and aborts the master's access with a backoff, so the processor can write the line back.

When the processor's write-back address strobe appears, the arbiter asserts hold again at once. It keeps the master backed off until the processor acknowledges the hold. Then it releases the backoff, and the master retries the aborted access at once. That retry produces a new snoop strobe, and the sequence begins again. Cache state and data transfer are outside the block.

Top module: `snoop_backoff_arbiter`

## Requirements
- R1: `cpu_snoop_n` equals `mst_ads_n` in the same clock, with no register between them (both active low).
- R2: After reset, `cpu_hold` is 1 (hold asserted) and `mst_backoff_n` is 1 (backoff inactive).
- R3: When `cpu_hitm_n` is 0 in the response window, in the clock after that window `cpu_hold` goes to 0 and `mst_backoff_n` goes to 0 together. The window is the cycle SNOOP_LAT clocks after the cycle in which the snoop strobe was low, with SNOOP_LAT = 2 by default.
- R4: When `cpu_hitm_n` is 1 in the response window, `cpu_hold` stays 1 and `mst_backoff_n` stays 1.
- R5: A low `cpu_hitm_n` outside the response window has no effect on `cpu_hold` or `mst_backoff_n`.
- R6: After a dirty-hit response, `cpu_hold` stays 0 until `cpu_ads_n` is sampled low. `cpu_hold` returns to 1 in the next clock.
- R7: `mst_backoff_n` stays 0 without a break from the dirty-hit response until `cpu_hlda` is sampled 1 after hold has been reasserted. It returns to 1 in the next clock.
- R8: After the backoff is released, the master's retried strobe is forwarded and starts a new snoop, and that new snoop has its own response window.
- R9: A master strobe that arrives while a snoop response is still pending does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_ads_n | input | 1 | Master address strobe, active low |
| cpu_snoop_n | output | 1 | Snoop strobe to the processor, active low |
| cpu_hitm_n | input | 1 | Processor hit-to-modified response, active low |
| cpu_ads_n | input | 1 | Processor address strobe, active low |
| cpu_hlda | input | 1 | Processor hold acknowledge, active high |
| cpu_hold | output | 1 | Hold request to the processor, active high |
| mst_backoff_n | output | 1 | Backoff to the master, active low |

## Verification
The bench drives a low hit response one cycle early, one cycle late and inside the window. An arbiter that samples the response at the wrong time would release hold on a clean snoop, or miss a dirty one. The bench holds off the processor's write-back strobe and its hold acknowledge for several cycles. A design that reasserted hold too early, or dropped the backoff before the acknowledge, would be caught in those cycles. The bench also sends a second master strobe during a pending snoop, to catch a design that restarts its window. It follows the release with a retried access, to catch a design that ignores the fresh snoop.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SNOOP   = 2'd1,
    ST_WB_WAIT = 2'd2,
    ST_WB_HOLD = 2'd3
  } sba_state_e;
endpackage

// File: rtl/sba_snoop_timer.sv
module sba_snoop_timer #(
  parameter int SNOOP_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic window
);
  localparam int CNT_W = $clog2(SNOOP_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(SNOOP_LAT);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign window = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sba_ctrl_fsm.sv
module sba_ctrl_fsm
  import sba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eads,
  input  logic window,
  input  logic hitm,
  input  logic cpu_ads,
  input  logic hlda,
  output logic start,
  output logic hold,
  output logic boff
);
  sba_state_e state_q;
  sba_state_e state_d;
  logic       hold_q;
  logic       hold_d;
  logic       boff_q;
  logic       boff_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (eads) begin
          state_d = ST_SNOOP;
          start   = 1'b1;
        end
      end
      ST_SNOOP: begin
        if (window) begin
          state_d = hitm ? ST_WB_WAIT : ST_IDLE;
        end
      end
      ST_WB_WAIT: begin
        if (cpu_ads) begin
          state_d = ST_WB_HOLD;
        end
      end
      ST_WB_HOLD: begin
        if (hlda) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    hold_d = (state_d != ST_WB_WAIT);
    boff_d = (state_d == ST_WB_WAIT) || (state_d == ST_WB_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b1;
      boff_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      boff_q  <= boff_d;
    end
  end

  assign hold = hold_q;
  assign boff = boff_q;
endmodule

// File: rtl/snoop_backoff_arbiter.sv
module snoop_backoff_arbiter #(
  parameter int SNOOP_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mst_ads_n,
  output logic cpu_snoop_n,
  input  logic cpu_hitm_n,
  input  logic cpu_ads_n,
  input  logic cpu_hlda,
  output logic cpu_hold,
  output logic mst_backoff_n
);
  logic start;
  logic window;
  logic boff;

  // The snoop strobe is forwarded in the same clock as the master strobe.
  assign cpu_snoop_n = mst_ads_n;

  sba_snoop_timer #(.SNOOP_LAT(SNOOP_LAT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .window (window)
  );

  sba_ctrl_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .eads    (!mst_ads_n),
    .window  (window),
    .hitm    (!cpu_hitm_n),
    .cpu_ads (!cpu_ads_n),
    .hlda    (cpu_hlda),
    .start   (start),
    .hold    (cpu_hold),
    .boff    (boff)
  );

  assign mst_backoff_n = !boff;
endmodule

// File: rtl/snoop_backoff_arbiter_chk.sv
module snoop_backoff_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_ads_n,
  input logic cpu_hlda,
  input logic cpu_hold,
  input logic mst_backoff_n
);
  // R3: hold is released only together with the backoff.
  a_r3_release_with_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> $fell(mst_backoff_n));
  // R3: the backoff is asserted only together with the hold release.
  a_r3_backoff_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_backoff_n) |-> $fell(cpu_hold));
  // R6: a processor strobe while hold is released brings hold back next clock.
  a_r6_hold_after_ads: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !cpu_ads_n) |=> cpu_hold);
  // R6: hold never rises without a processor strobe.
  a_r6_hold_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |-> !$past(cpu_ads_n));
  // R7: the backoff is released only after an acknowledge.
  a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_backoff_n) |-> $past(cpu_hlda) && $past(cpu_hold));
  // R7: an acknowledge under reasserted hold ends the backoff next clock.
  a_r7_release_on_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_backoff_n && cpu_hold && cpu_hlda) |=> mst_backoff_n);
  // R7: hold is never released while the master is free.
  a_r7_no_free_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |-> !mst_backoff_n);
endmodule

bind snoop_backoff_arbiter snoop_backoff_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ads_n     (cpu_ads_n),
  .cpu_hlda      (cpu_hlda),
  .cpu_hold      (cpu_hold),
  .mst_backoff_n (mst_backoff_n)
);

// File: tb/snoop_backoff_arbiter_test.sv
module snoop_backoff_arbiter_test;
  logic clk;
  logic rst_n;
  logic mst_ads_n;
  logic cpu_snoop_n;
  logic cpu_hitm_n;
  logic cpu_ads_n;
  logic cpu_hlda;
  logic cpu_hold;
  logic mst_backoff_n;

  int checks;
  int errors;
  bit done;

  snoop_backoff_arbiter uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_ads_n     (mst_ads_n),
    .cpu_snoop_n   (cpu_snoop_n),
    .cpu_hitm_n    (cpu_hitm_n),
    .cpu_ads_n     (cpu_ads_n),
    .cpu_hlda      (cpu_hlda),
    .cpu_hold      (cpu_hold),
    .mst_backoff_n (mst_backoff_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one master strobe. The response is driven low in window cycle
  // hit_at (1 = one early, 2 = window, 3 = one late, 0 = never).
  // Returns at the negedge after the window cycle.
  task automatic snoop(input int hit_at);
    @(negedge clk);
    mst_ads_n  = 1'b0;
    cpu_hitm_n = (hit_at == 0 || hit_at > 0) ? 1'b1 : 1'b1;
    #1 chk("R1 snoop strobe low", cpu_snoop_n, 1'b0);
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      mst_ads_n  = 1'b1;
      cpu_hitm_n = (hit_at == c) ? 1'b0 : 1'b1;
      if (c == 1) begin
        #1 chk("R1 snoop strobe high", cpu_snoop_n, 1'b1);
      end
      if (c == 3) break;
    end
  endtask

  task automatic t_reset;
    chk("R2 hold after reset", cpu_hold, 1'b1);
    chk("R2 backoff after reset", mst_backoff_n, 1'b1);
  endtask

  task automatic t_clean;
    snoop(0);
    chk("R4 hold kept on clean", cpu_hold, 1'b1);
    chk("R4 backoff idle on clean", mst_backoff_n, 1'b1);
    @(negedge clk);
    chk("R4 hold still kept", cpu_hold, 1'b1);
  endtask

  task automatic t_outside;
    snoop(1);
    chk("R5 early hit ignored hold", cpu_hold, 1'b1);
    chk("R5 early hit ignored backoff", mst_backoff_n, 1'b1);
    snoop(3);
    @(negedge clk);
    cpu_hitm_n = 1'b1;
    chk("R5 late hit ignored hold", cpu_hold, 1'b1);
    chk("R5 late hit ignored backoff", mst_backoff_n, 1'b1);
  endtask

  task automatic t_dirty;
    // Window is cycle 2: hit_at=2 drives low exactly there.
    @(negedge clk);
    mst_ads_n = 1'b0;
    @(negedge clk);
    mst_ads_n = 1'b1;
    @(negedge clk);
    cpu_hitm_n = 1'b0;
    chk("R3 hold before response edge", cpu_hold, 1'b1);
    @(negedge clk);
    cpu_hitm_n = 1'b1;
    chk("R3 hold released", cpu_hold, 1'b0);
    chk("R3 backoff asserted", mst_backoff_n, 1'b0);
    cpu_hlda = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 hold waits for strobe", cpu_hold, 1'b0);
    end
    cpu_ads_n = 1'b0;
    @(negedge clk);
    cpu_ads_n = 1'b1;
    chk("R6 hold back after strobe", cpu_hold, 1'b1);
    chk("R7 backoff kept", mst_backoff_n, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 backoff held before ack", mst_backoff_n, 1'b0);
    end
    cpu_hlda = 1'b1;
    chk("R7 backoff held in ack cycle", mst_backoff_n, 1'b0);
    @(negedge clk);
    chk("R7 backoff released", mst_backoff_n, 1'b1);
    chk("R7 hold stays", cpu_hold, 1'b1);
  endtask

  task automatic t_retry;
    // Retry at once, dirty again, then release.
    mst_ads_n = 1'b0;
    #1 chk("R8 retry strobe forwarded", cpu_snoop_n, 1'b0);
    @(negedge clk);
    mst_ads_n = 1'b1;
    @(negedge clk);
    cpu_hitm_n = 1'b0;
    @(negedge clk);
    cpu_hitm_n = 1'b1;
    chk("R8 retry snoop released hold", cpu_hold, 1'b0);
    chk("R8 retry snoop backoff", mst_backoff_n, 1'b0);
    cpu_hlda = 1'b0;
    cpu_ads_n = 1'b0;
    @(negedge clk);
    cpu_ads_n = 1'b1;
    cpu_hlda = 1'b1;
    @(negedge clk);
    chk("R8 retry backoff released", mst_backoff_n, 1'b1);
  endtask

  task automatic t_restrike;
    // Second strobe one cycle after the first; response low only in the
    // window the second strobe would have opened.
    @(negedge clk);
    mst_ads_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mst_ads_n = 1'b1;
    @(negedge clk);
    cpu_hitm_n = 1'b0;
    @(negedge clk);
    cpu_hitm_n = 1'b1;
    chk("R9 no restart hold", cpu_hold, 1'b1);
    chk("R9 no restart backoff", mst_backoff_n, 1'b1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    mst_ads_n = 1'b1;
    cpu_hitm_n = 1'b1;
    cpu_ads_n = 1'b1;
    cpu_hlda = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_outside();
    t_dirty();
    t_retry();
    t_restrike();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule